// File: doc/BRIEF.md
# Word-Serial SHA-1 Compression Core

This block performs one SHA-1 compression step on a 512-bit message block. The caller streams in sixteen 32-bit words with a valid/ready handshake. Five 32-bit digest words later come out over the same word-wide path. Input and output use the path at different times, never together. The core runs round t in the same cycle that it accepts word t, so it finishes the first sixteen rounds while the block is still arriving. The remaining 64 rounds use schedule words that it expands on the fly in a sixteen-entry ring. The chaining value comes from one of two sources. It can be the standard SHA-1 starting vector, or a 160-bit value that the caller supplies, such as the digest of the previous block or a stored midstate.

Padding, length encoding and chaining across several blocks are the caller's job. For each block the caller pulses `start` while the core is idle and selects the chaining source with `use_cv`. It then offers the sixteen words, most significant word of the block first, and collects five words after `done`.

The control is a four-state machine:
- IDLE moves to LOAD on `start`.
- LOAD stays in LOAD while it takes words, and moves to CRUNCH on the sixteenth accepted word.
- CRUNCH moves to EMIT after round 79.
- EMIT moves back to IDLE after the fifth output word.

Top module: `sha1_wordcore`

## Requirements
- R1: While reset is asserted and after reset is released, `in_ready`, `out_valid` and `done` are low and the core is in IDLE.
- R2: A `start` sampled high in IDLE moves the core to LOAD, so `in_ready` is high from the next cycle on. The `use_cv` and `cv_in` values sampled on that same edge set the chaining value.
- R3: In LOAD a word is taken on each clock edge where `in_valid` and `in_ready` are both high. A cycle with `in_valid` low keeps the core in LOAD without consuming anything. Exactly sixteen words are taken, then `in_ready` falls. Words offered outside LOAD are not taken and do not change the digest.
- R4: `in_ready` and `out_valid` are never high in the same cycle.
- R5: With `use_cv` low, the digest is the SHA-1 compression of the block, starting from 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0. Word 0 of the block is the first word accepted. For example, the padded block for "abc" gives a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R6: With `use_cv` high, `cv_in[159:128]` is the first chaining word and `cv_in[31:0]` is the fifth. The digest is the compression from that chaining value, so feeding the first block's digest back in reproduces a two-block hash.
- R7: `out_valid` first rises 64 clock edges after the edge that accepted the sixteenth word. Without input stalls, a whole block takes 86 cycles from `start` to the last output word, which is under 165.
- R8: `done` is high for exactly one cycle, together with the first output word. The five digest words come on five consecutive cycles, first chaining word first. After that `out_valid` is low and the core is in IDLE.
- R9: A `start` outside IDLE is ignored. It changes neither the chaining value, nor the word count, nor the digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a block when the core is idle |
| use_cv | input | 1 | Selects `cv_in` (1) or the standard starting vector (0) at start |
| cv_in | input | 160 | External chaining value, first word in the top bits |
| in_valid | input | 1 | Offered message word is valid |
| in_data | input | 32 | Message word |
| in_ready | output | 1 | Core accepts a message word this cycle |
| out_valid | output | 1 | Digest word on `out_data` is valid |
| out_data | output | 32 | Digest word |
| done | output | 1 | Marks the first digest word |

## Verification
The properties assume that every control input has a known value on each clock edge after reset is released, and that reset is held low from time zero until the first edges have passed. The latency and burst-length properties also assume that a block is never cut short by a reset in mid-flight. The stimulus changes inputs only one time unit after a rising edge and releases reset once. It then runs each block to the end of its output burst before it pulses `start` again. It deliberately offers words during CRUNCH and pulses `start` during LOAD, so that the ignore rules are exercised.

// File: rtl/sha1_core_pkg.sv
package sha1_core_pkg;

    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int DIG_WORDS = 5;
    localparam int ROUNDS    = 80;
    localparam int STAGE_LEN = 20;
    localparam int IDX_W     = $clog2(BLK_WORDS);
    localparam int RND_W     = $clog2(ROUNDS + 1);
    localparam int DIG_W     = WORD_W * DIG_WORDS;

    // schedule taps, as distances back from the slot being written
    localparam int TAP_A = 3;
    localparam int TAP_B = 8;
    localparam int TAP_C = 14;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } state5_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CRUNCH,
        ST_EMIT
    } phase_e;

    localparam logic [DIG_W-1:0] STD_IV =
        160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t stage_const(input logic [RND_W-1:0] t);
        if (t < RND_W'(STAGE_LEN))          return 32'h5A827999;
        else if (t < RND_W'(2 * STAGE_LEN)) return 32'h6ED9EBA1;
        else if (t < RND_W'(3 * STAGE_LEN)) return 32'h8F1BBCDC;
        else                                return 32'hCA62C1D6;
    endfunction

    function automatic word_t stage_mix(input logic [RND_W-1:0] t,
                                        input word_t b, input word_t c, input word_t d);
        if (t < RND_W'(STAGE_LEN))          return (b & c) | (~b & d);
        else if (t < RND_W'(2 * STAGE_LEN)) return b ^ c ^ d;
        else if (t < RND_W'(3 * STAGE_LEN)) return (b & c) | (b & d) | (c & d);
        else                                return b ^ c ^ d;
    endfunction

endpackage

// File: rtl/sha1_sched.sv
module sha1_sched
    import sha1_core_pkg::*;
#(
    parameter int DEPTH = BLK_WORDS
) (
    input  logic                     clk,
    input  logic                     step,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  word_t                    fresh,
    input  logic                     take_fresh,
    output word_t                    w_out
);
    localparam int IW = $clog2(DEPTH);

    word_t           ring [DEPTH];
    logic [IW-1:0]   ia, ib, ic;
    word_t           expanded;

    // slot idx still holds w[t-16] until it is overwritten
    assign ia       = idx - IW'(TAP_A);
    assign ib       = idx - IW'(TAP_B);
    assign ic       = idx - IW'(TAP_C);
    assign expanded = rotl(ring[ia] ^ ring[ib] ^ ring[ic] ^ ring[idx], 1);
    assign w_out    = take_fresh ? fresh : expanded;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (step && idx == IW'(g)) begin
                ring[g] <= w_out;
            end
        end
    end

endmodule

// File: rtl/sha1_round.sv
module sha1_round
    import sha1_core_pkg::*;
(
    input  state5_t          cur,
    input  word_t            w,
    input  logic [RND_W-1:0] t,
    output state5_t          nxt
);
    word_t sum;

    always_comb begin
        sum   = rotl(cur.a, 5) + stage_mix(t, cur.b, cur.c, cur.d)
              + cur.e + stage_const(t) + w;
        nxt.a = sum;
        nxt.b = cur.a;
        nxt.c = rotl(cur.b, 30);
        nxt.d = cur.c;
        nxt.e = cur.d;
    end

endmodule

// File: rtl/sha1_fsm.sv
module sha1_fsm
    import sha1_core_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_valid,
    output phase_e           phase,
    output logic [RND_W-1:0] rnd,
    output logic             arm,
    output logic             step,
    output logic             seal,
    output logic             shift,
    output logic             in_ready,
    output logic             out_valid,
    output logic             done
);
    localparam int OW = $clog2(DIG_WORDS);

    phase_e          state_q, state_d;
    logic [OW-1:0]   oidx_q;
    logic            last_load, last_round, last_word;

    assign last_load  = (rnd == RND_W'(BLK_WORDS - 1));
    assign last_round = (rnd == RND_W'(ROUNDS - 1));
    assign last_word  = (oidx_q == OW'(DIG_WORDS - 1));
    assign phase      = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)                  state_d = ST_LOAD;
            ST_LOAD:   if (in_valid && last_load)  state_d = ST_CRUNCH;
            ST_CRUNCH: if (last_round)             state_d = ST_EMIT;
            ST_EMIT:   if (last_word)              state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        arm       = 1'b0;
        step      = 1'b0;
        seal      = 1'b0;
        shift     = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   arm = start;
            ST_LOAD: begin
                in_ready = 1'b1;
                step     = in_valid;
            end
            ST_CRUNCH: begin
                step = 1'b1;
                seal = last_round;
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                shift     = 1'b1;
                done      = (oidx_q == '0);
            end
        endcase
    end

    // round and output-word counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd    <= '0;
            oidx_q <= '0;
        end else begin
            if (arm)       rnd <= '0;
            else if (step) rnd <= rnd + 1'b1;
            if (shift)     oidx_q <= oidx_q + 1'b1;
            else           oidx_q <= '0;
        end
    end

endmodule

// File: rtl/sha1_wordcore.sv
module sha1_wordcore
    import sha1_core_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         use_cv,
    input  logic [159:0] cv_in,
    input  logic         in_valid,
    input  logic [31:0]  in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [31:0]  out_data,
    output logic         done
);
    phase_e             phase;
    logic [RND_W-1:0]   rnd;
    logic               arm, step, seal, shift;
    state5_t            chain_q, work_q, work_nx;
    logic [DIG_W-1:0]   res_q, sum;
    word_t              w_t;

    sha1_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .phase     (phase),
        .rnd       (rnd),
        .arm       (arm),
        .step      (step),
        .seal      (seal),
        .shift     (shift),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .done      (done)
    );

    sha1_sched #(.DEPTH(BLK_WORDS)) u_sched (
        .clk        (clk),
        .step       (step),
        .idx        (rnd[IDX_W-1:0]),
        .fresh      (in_data),
        .take_fresh (phase == ST_LOAD),
        .w_out      (w_t)
    );

    sha1_round u_round (
        .cur (work_q),
        .w   (w_t),
        .t   (rnd),
        .nxt (work_nx)
    );

    for (genvar g = 0; g < DIG_WORDS; g++) begin : g_fold
        assign sum[g*WORD_W +: WORD_W] =
            chain_q[g*WORD_W +: WORD_W] + work_nx[g*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            work_q  <= '0;
            res_q   <= '0;
        end else begin
            if (arm) begin
                chain_q <= use_cv ? cv_in : STD_IV;
                work_q  <= use_cv ? cv_in : STD_IV;
            end else if (step) begin
                work_q  <= work_nx;
            end
            if (seal)       res_q <= sum;
            else if (shift) res_q <= res_q << WORD_W;
        end
    end

    assign out_data = res_q[DIG_W-1 -: WORD_W];

endmodule

// File: rtl/sha1_wordcore_chk.sv
module sha1_wordcore_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic done
);
    logic [7:0] gap_q;
    logic [3:0] burst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            burst_q <= '0;
        end else begin
            if (in_ready)             gap_q <= '0;
            else if (gap_q != 8'hFF)  gap_q <= gap_q + 1'b1;
            if (!out_valid)           burst_q <= '0;
            else if (burst_q != 4'hF) burst_q <= burst_q + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!in_ready && !out_valid && !done));

    assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);

    assert_half_duplex_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (gap_q == 8'd64));

    assert_done_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && !$past(out_valid)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_burst_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (burst_q == 4'd5));

endmodule

bind sha1_wordcore sha1_wordcore_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .done      (done)
);

// File: tb/sha1_wordcore_tb.sv
module sha1_wordcore_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         use_cv = 1'b0;
    logic [159:0] cv_in = '0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_data = '0;
    logic         in_ready, out_valid, done;
    logic [31:0]  out_data;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int last_acc = 0;
    logic [31:0] cur_blk [16];

    localparam logic [159:0] IV0 = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

    sha1_wordcore u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .use_cv(use_cv), .cv_in(cv_in),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .done(done)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [159:0] ref_compress(input logic [159:0] h, input logic [511:0] m);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, x, tmp;
        for (int i = 0; i < 16; i++) w[i] = m[511-32*i -: 32];
        for (int i = 16; i < 80; i++) begin
            x = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
            w[i] = {x[30:0], x[31]};
        end
        {a, b, c, d, e} = h;
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                    k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                    k = 32'hCA62C1D6; end
            tmp = {a[26:0], a[31:27]} + f + e + k + w[i];
            e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = tmp;
        end
        return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
    endfunction

    // behavioural reference: 0 idle, 1 load, 2 crunch, 3 emit
    int           m_st = 0;
    int           m_cnt = 0;
    int           m_run = 0;
    int           m_oi = 0;
    logic [159:0] m_cv = '0;
    logic [511:0] m_blk = '0;
    logic [159:0] m_dig = '0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: if (start) begin
                    m_st = 1; m_cnt = 0;
                    m_cv = use_cv ? cv_in : IV0;
                end
                1: if (in_valid) begin
                    m_blk[511-32*m_cnt -: 32] = in_data;
                    m_cnt++;
                    if (m_cnt == 16) begin m_st = 2; m_run = 0; end
                end
                2: begin
                    m_run++;
                    if (m_run == 64) begin
                        m_st = 3; m_oi = 0;
                        m_dig = ref_compress(m_cv, m_blk);
                    end
                end
                default: begin
                    m_oi++;
                    if (m_oi == 5) m_st = 0;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(in_ready === (m_st == 1), "R3 in_ready", 160'(in_ready), 160'(m_st == 1));
            chk(out_valid === (m_st == 3), "R7 out_valid", 160'(out_valid), 160'(m_st == 3));
            chk(done === (m_st == 3 && m_oi == 0), "R8 done", 160'(done), 160'(m_st == 3 && m_oi == 0));
            chk(!(in_ready && out_valid), "R4 duplex", 160'({in_ready, out_valid}), 160'(0));
            if (m_st == 3)
                chk(out_data === m_dig[159-32*m_oi -: 32], "R5 out_data",
                    160'(out_data), 160'(m_dig[159-32*m_oi -: 32]));
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic send_block(input logic [159:0] cv, input bit ext,
                              input bit gaps, input bit glitch, input bit junk);
        bit acc;
        @(posedge clk); #1;
        start = 1; use_cv = ext; cv_in = cv;
        @(posedge clk); #1;
        start = 0; use_cv = 0; cv_in = '0;
        chk(in_ready === 1'b1, "R2 ready after start", 160'(in_ready), 160'(1));
        for (int i = 0; i < 16; i++) begin
            if (gaps && i[0]) begin
                in_valid = 0; in_data = 32'hDEAD0000 + i;
                if (glitch && i == 5) begin
                    start = 1; use_cv = 1; cv_in = {5{32'h13579BDF}};
                end
                @(posedge clk); #1;
                start = 0; use_cv = 0; cv_in = '0;
            end
            in_valid = 1; in_data = cur_blk[i];
            do begin
                acc = in_ready;
                @(posedge clk); #1;
            end while (!acc);
        end
        in_valid = 0;
        last_acc = cyc;
        chk(in_ready === 1'b0, "R3 ready falls after 16", 160'(in_ready), 160'(0));
        if (junk) begin
            for (int j = 0; j < 3; j++) begin
                in_valid = 1; in_data = 32'hBAD0BAD0 ^ j;
                if (j == 1) begin start = 1; use_cv = 1; cv_in = '1; end
                @(posedge clk); #1;
                start = 0; use_cv = 0; cv_in = '0;
            end
            in_valid = 0;
        end
    endtask

    task automatic collect(output logic [159:0] dig);
        @(negedge clk);
        while (!done) @(negedge clk);
        chk(cyc - last_acc == 64, "R7 latency", 160'(cyc - last_acc), 160'(64));
        dig[159:128] = out_data;
        for (int k = 1; k < 5; k++) begin
            @(negedge clk);
            chk(out_valid === 1'b1 && done === 1'b0, "R8 burst", 160'({out_valid, done}), 160'(2));
            dig[159-32*k -: 32] = out_data;
        end
        @(negedge clk);
        chk(!out_valid && !done && !in_ready, "R8 back to idle", 160'({out_valid, done, in_ready}), 160'(0));
    endtask

    logic [159:0] d1, d2;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!in_ready && !out_valid && !done, "R1 reset outputs", 160'({in_ready, out_valid, done}), 160'(0));
        rst_n = 1;
        @(negedge clk);
        chk(!in_ready && !out_valid && !done, "R1 idle after reset", 160'({in_ready, out_valid, done}), 160'(0));

        // "abc", standard vector, no stalls
        for (int i = 0; i < 16; i++) cur_blk[i] = 32'h0;
        cur_blk[0] = 32'h61626380; cur_blk[15] = 32'h00000018;
        send_block('0, 0, 0, 0, 0);
        collect(d1);
        chk(d1 === 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D, "R5 abc digest", d1,
            160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);

        // same block with stalls, start pulses in LOAD/CRUNCH, junk words in CRUNCH
        send_block('0, 0, 1, 1, 1);
        collect(d1);
        chk(d1 === 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D, "R9 start and junk ignored", d1,
            160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);

        // two-block message, second block chained through cv_in
        cur_blk[0]  = 32'h61626364; cur_blk[1]  = 32'h62636465; cur_blk[2]  = 32'h63646566;
        cur_blk[3]  = 32'h64656667; cur_blk[4]  = 32'h65666768; cur_blk[5]  = 32'h66676869;
        cur_blk[6]  = 32'h6768696A; cur_blk[7]  = 32'h68696A6B; cur_blk[8]  = 32'h696A6B6C;
        cur_blk[9]  = 32'h6A6B6C6D; cur_blk[10] = 32'h6B6C6D6E; cur_blk[11] = 32'h6C6D6E6F;
        cur_blk[12] = 32'h6D6E6F70; cur_blk[13] = 32'h6E6F7071; cur_blk[14] = 32'h80000000;
        cur_blk[15] = 32'h0;
        send_block('0, 0, 0, 0, 0);
        collect(d1);
        for (int i = 0; i < 15; i++) cur_blk[i] = 32'h0;
        cur_blk[15] = 32'h000001C0;
        send_block(d1, 1, 1, 0, 0);
        collect(d2);
        chk(d2 === 160'h84983E44_1C3BD26E_BAAE4AA1_F95129E5_E54670F1, "R6 chained digest", d2,
            160'h84983E44_1C3BD26E_BAAE4AA1_F95129E5_E54670F1);

        // arbitrary midstate and words
        for (int i = 0; i < 16; i++) cur_blk[i] = 32'h9E3779B9 * (i + 1) ^ 32'h5BD1E995;
        send_block(160'h01234567_89ABCDEF_FEDCBA98_76543210_0F1E2D3C, 1, 0, 0, 1);
        collect(d2);
        chk(d2 === ref_compress(160'h01234567_89ABCDEF_FEDCBA98_76543210_0F1E2D3C,
                                {cur_blk[0], cur_blk[1], cur_blk[2], cur_blk[3],
                                 cur_blk[4], cur_blk[5], cur_blk[6], cur_blk[7],
                                 cur_blk[8], cur_blk[9], cur_blk[10], cur_blk[11],
                                 cur_blk[12], cur_blk[13], cur_blk[14], cur_blk[15]}),
            "R6 midstate digest", d2, m_dig);

        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule